// File: doc/BRIEF.md
# Serial-Loaded Latched Switch Control

This block is the digital control core of a multi-channel switch driver. A serial bit stream is shifted into a channel-wide shift register, one bit for each rising edge of a shift clock input. A bank of level-sensitive latch bits sits between the shift register and the switch-on outputs. While the active-low latch enable is low, the outputs follow the shift register. When the enable rises, the outputs freeze at the value they show at that moment. A clear input forces every output off. The last shift stage is brought out as a serial output so that several blocks can be chained.

All logic runs on a single system clock. The shift clock, latch enable and clear are inputs that are synchronous to that clock. The block detects shift clock edges itself. The latch's transparent path is combinational, so a change of the enable or the clear reaches the outputs in the same cycle.

Top module: `swctl_top`

## Requirements
- R1: Each rising edge of `shiftClk` (low in one sampled cycle, high in the next) shifts `din` into stage 0 and moves stage k to stage k+1 at that system clock edge. Stage k drives `sw[k]`, so after eight shifts the first bit entered controls `sw[7]`.
- R2: A shift happens only on a low-to-high transition of `shiftClk`. Holding it high or low for any number of cycles shifts nothing.
- R3: While `leN` is low and `clr` is low, `sw` equals the shift register contents and shows each shift right after the clock edge that performs it.
- R4: When `leN` rises, `sw` keeps the value it showed just before the rise, and holds it while `leN` stays high.
- R5: While `leN` is high, shifting has no effect on `sw`.
- R6: While `clr` is high, all of `sw` is 0 (off), in the same cycle and whatever the other inputs are.
- R7: `clr` does not touch the shift register: shifting and `dout` carry on while it is high. Once `clr` has been high across a clock edge and is released with `leN` high, `sw` stays 0 until `leN` goes low.
- R8: `dout` equals shift stage 7 and changes only at a clock edge that performs a shift.
- R9: After reset (`rstN` low), the shift register, the latch bits, `sw` and `dout` are all 0. A `shiftClk` that is already high when reset ends is not counted as a rising edge.
- R10: Each output bit depends only on its own stage, so any bit pattern, including a single walking one, appears unchanged on `sw`.
- R11: If `leN` is sampled high at the same clock edge that performs a shift, the latch keeps the value from before that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| din | input | 1 | Serial data in |
| shiftClk | input | 1 | Shift clock; a shift happens on each rising edge |
| leN | input | 1 | Active-low latch enable (low = transparent) |
| clr | input | 1 | Forces all switch outputs off |
| sw | output | 8 | Switch-on outputs, 1 = on |
| dout | output | 1 | Serial data out (last stage) |

## Verification
Two events can fall in the same cycle: a shift edge and the closing of the latch, and also a shift edge and an active clear. The bench makes both happen by driving the `shiftClk` rise and the `leN` rise, or the `shiftClk` rise with `clr` high, at the same falling edge. A behavioural model decides the outcome: in the first case the pre-shift value must be frozen on `sw`; in the second, `sw` must stay 0 while `dout` still moves. The model compares `sw` and `dout` on every cycle.

// File: rtl/swctl_pkg.sv
package swctl_pkg;
  localparam int CHANNELS = 8;

  typedef struct packed {
    logic shiftEn;    // rising shift clock seen this cycle
    logic latchOpen;  // latch transparent
    logic clearLatch; // force outputs off, wipe held bits
  } ctlStrobes_t;
endpackage

// File: rtl/swctl_ctrl.sv
module swctl_ctrl
  import swctl_pkg::*;
(
  input  logic        sysClk,
  input  logic        rstN,
  input  logic        shiftClk,
  input  logic        leN,
  input  logic        clr,
  output ctlStrobes_t strobes
);
  logic shiftClkQ;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) shiftClkQ <= 1'b1;
    else       shiftClkQ <= shiftClk;
  end

  always_comb begin
    strobes.shiftEn    = shiftClk & ~shiftClkQ;
    strobes.latchOpen  = ~leN;
    strobes.clearLatch = clr;
  end

  // R2: a shift strobe needs shiftClk low in the previous cycle
  assert_edge_only_R2: assert property (@(posedge sysClk) disable iff (!rstN)
    strobes.shiftEn |-> !$past(shiftClk));
endmodule

// File: rtl/swctl_datapath.sv
module swctl_datapath
  import swctl_pkg::*;
#(
  parameter int WIDTH = CHANNELS
) (
  input  logic             sysClk,
  input  logic             rstN,
  input  logic             din,
  input  ctlStrobes_t      strobes,
  output logic [WIDTH-1:0] sw,
  output logic             dout
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] shiftReg;
  logic [WIDTH-1:0] shiftNext;
  logic [WIDTH-1:0] holdReg;

  always_comb begin
    shiftNext = shiftReg;
    if (strobes.shiftEn) shiftNext = {shiftReg[TOP-1:0], din};
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else       shiftReg <= shiftNext;
  end

  // held bits track the register's next value while the latch is open
  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN)                   holdReg <= '0;
    else if (strobes.clearLatch) holdReg <= '0;
    else if (strobes.latchOpen)  holdReg <= shiftNext;
  end

  // level-sensitive path, one mux per channel
  for (genvar ch = 0; ch < WIDTH; ch++) begin : g_chan
    always_comb begin
      if (strobes.clearLatch)     sw[ch] = 1'b0;
      else if (strobes.latchOpen) sw[ch] = shiftReg[ch];
      else                        sw[ch] = holdReg[ch];
    end
  end

  assign dout = shiftReg[TOP];

  // R8: no shift, no change on the serial output
  assert_dout_quiet_R8: assert property (@(posedge sysClk) disable iff (!rstN)
    !$past(strobes.shiftEn) |-> $stable(dout));

  // R1: after a shift the serial output carries the previous stage
  assert_dout_step_R1: assert property (@(posedge sysClk) disable iff (!rstN)
    $past(strobes.shiftEn) |-> dout == $past(shiftReg[TOP-1]));

  // R5: closed latch, no clear: outputs do not move
  assert_hold_stable_R5: assert property (@(posedge sysClk) disable iff (!rstN)
    (!strobes.latchOpen && !strobes.clearLatch &&
     $past(!strobes.latchOpen) && $past(!strobes.clearLatch)) |-> $stable(sw));

  // R7: clear released with the latch closed leaves all outputs off
  assert_clear_release_R7: assert property (@(posedge sysClk) disable iff (!rstN)
    ($past(strobes.clearLatch) && !strobes.clearLatch && !strobes.latchOpen) |-> sw == '0);
endmodule

// File: rtl/swctl_top.sv
module swctl_top
  import swctl_pkg::*;
(
  input  logic                sysClk,
  input  logic                rstN,
  input  logic                din,
  input  logic                shiftClk,
  input  logic                leN,
  input  logic                clr,
  output logic [CHANNELS-1:0] sw,
  output logic                dout
);
  ctlStrobes_t strobes;

  swctl_ctrl u_ctrl (
    .sysClk  (sysClk),
    .rstN    (rstN),
    .shiftClk(shiftClk),
    .leN     (leN),
    .clr     (clr),
    .strobes (strobes)
  );

  swctl_datapath #(.WIDTH(CHANNELS)) u_datapath (
    .sysClk (sysClk),
    .rstN   (rstN),
    .din    (din),
    .strobes(strobes),
    .sw     (sw),
    .dout   (dout)
  );
endmodule

// File: tb/swctl_top_tb.sv
module swctl_top_tb;
  logic       sysClk = 1'b0;
  logic       rstN = 1'b0;
  logic       din = 1'b0;
  logic       shiftClk = 1'b0;
  logic       leN = 1'b1;
  logic       clr = 1'b0;
  logic [7:0] sw;
  logic       dout;

  int    nChecks = 0;
  int    nFails = 0;
  string curReq = "R9";
  bit    done = 1'b0;

  // behavioural model
  bit mBits[$];
  bit mHold[8];
  bit mPrevClk = 1'b1;

  swctl_top u_dut (
    .sysClk(sysClk), .rstN(rstN), .din(din), .shiftClk(shiftClk),
    .leN(leN), .clr(clr), .sw(sw), .dout(dout)
  );

  always #4 sysClk = ~sysClk;

  function automatic logic [7:0] modelShift();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = mBits[i];
    return v;
  endfunction

  function automatic logic [7:0] modelHold();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = mHold[i];
    return v;
  endfunction

  initial for (int i = 0; i < 8; i++) mBits.push_back(1'b0);

  always @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) begin mBits[i] = 1'b0; mHold[i] = 1'b0; end
      mPrevClk = 1'b1;
    end else begin
      if (shiftClk && !mPrevClk) begin
        mBits.push_front(din);
        void'(mBits.pop_back());
      end
      if (clr) for (int i = 0; i < 8; i++) mHold[i] = 1'b0;
      else if (!leN) for (int i = 0; i < 8; i++) mHold[i] = mBits[i];
      mPrevClk = shiftClk;
    end
  end

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: {sw,dout} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // compare every cycle, well after inputs settle
  always @(negedge sysClk) begin
    #2;
    if (rstN && !done) begin
      logic [7:0] expSw;
      if (clr)       expSw = 8'h00;
      else if (!leN) expSw = modelShift();
      else           expSw = modelHold();
      check(curReq, {sw, dout}, {expSw, modelShift()[7]});
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge sysClk);
  endtask

  task automatic shiftBit(input logic b);
    @(negedge sysClk); din = b; shiftClk = 1'b1;
    @(negedge sysClk); shiftClk = 1'b0;
  endtask

  task automatic shiftByte(input logic [7:0] v); // v[7] goes in first
    for (int i = 7; i >= 0; i--) shiftBit(v[i]);
  endtask

  initial begin
    #1000000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    shiftClk = 1'b1; // high at reset release must not count (R9)
    idle(3);
    #2 check("R9 reset", {sw, dout}, 9'h000);
    @(negedge sysClk); rstN = 1'b1;
    curReq = "R9"; idle(3);
    shiftClk = 1'b0; idle(1);

    // R1 / R3: transparent load, first bit lands on sw[7]
    curReq = "R3"; leN = 1'b0;
    shiftByte(8'b1011_0010);
    curReq = "R1"; idle(1);
    #2 check("R1 byte", {sw, dout}, {8'b1011_0010, 1'b1});

    // R2: level of shift clock does not shift
    curReq = "R2";
    @(negedge sysClk); din = 1'b0; shiftClk = 1'b1;
    idle(5); shiftClk = 1'b0; din = 1'b1; idle(5);
    #2 check("R2 single", {sw, dout}, {8'b0110_0100, 1'b0});

    // R4 / R5: freeze, then shift under closed latch
    curReq = "R4"; @(negedge sysClk); leN = 1'b1; idle(2);
    curReq = "R5"; shiftByte(8'b0101_1100);
    idle(1); #2 check("R5 frozen", {sw, dout}, {8'b0110_0100, 1'b0});

    // R11: latch closes on the same edge as a shift
    curReq = "R11"; @(negedge sysClk); leN = 1'b0; idle(2);
    @(negedge sysClk); leN = 1'b1; din = 1'b1; shiftClk = 1'b1;
    @(negedge sysClk); shiftClk = 1'b0; idle(1);
    #2 check("R11 preshift", {sw, dout}, {8'b0101_1100, 1'b1});

    // R6 / R7: clear with shifts in the same cycles
    curReq = "R6"; @(negedge sysClk); leN = 1'b0; clr = 1'b1;
    shiftByte(8'b1110_0001);
    @(negedge sysClk); leN = 1'b1;
    curReq = "R7"; @(negedge sysClk); clr = 1'b0; idle(3);
    #2 check("R7 stays off", {sw, dout}, {8'h00, 1'b1});
    shiftBit(1'b0); idle(1);
    @(negedge sysClk); leN = 1'b0; idle(1);
    #2 check("R7 reload", {sw, dout}, {8'b1100_0010, 1'b1});

    // R8 / R10: walking one through the chain
    curReq = "R10";
    shiftByte(8'b0000_0001);
    for (int k = 0; k < 8; k++) begin
      curReq = (k % 2) ? "R8" : "R10";
      shiftBit(1'b0);
    end
    curReq = "R10"; shiftByte(8'b1010_0101); idle(2);
    #2 check("R10 pattern", {sw, dout}, {8'b1010_0101, 1'b1});

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule